// File: doc/BRIEF.md
# Branch Target Trace Serializer

This block runs beside a processor pipeline and reports changes of program flow on two 4-bit trace ports: a status port and a data port. Whenever the pipeline signals a taken branch, the status port shows the branch code one cycle later. Some branches take their target from a register, such as a jump through an address register, a return, or an exception vector. For these, the block can also report the target address, provided that address display is enabled in the configuration inputs.

In that case the branch code is followed by a length marker on the status port. The data port then streams the low 2, 3 or 4 bytes of the target, one nibble per clock, starting with the least significant nibble. A second register-target branch can arrive while a transfer is still running. It is parked in a one-entry holding slot and sent once the current transfer ends. A third such request, arriving while the slot is occupied, raises a stall toward the pipeline. The block does not accept that request until the stall clears.

Top module: `btrace_ser`

## Requirements
- R1: Reset is active-low. While it is asserted, and in the first cycle after it, the status port and the data port read 0x0 and the stall is low. Reset also discards any transfer in flight and the holding slot, so no nibbles appear after reset is released.
- R2: A taken-branch strobe that is accepted (that is, not stalled) makes the status port read 0x5 in the following cycle. This applies whether or not the branch takes its target from a register.
- R3: For an accepted branch that has a register target while display is on, the status port shows a length marker in the cycle after the 0x5. The size code selects the marker: 00 gives 0x9 (2 bytes), 01 gives 0xA (3 bytes), and 10 or 11 gives 0xB (4 bytes).
- R4: Starting in the cycle after the length marker, the data port carries target bits [3:0], [7:4], and so on, upward, one nibble per cycle. It sends 4, 6 or 8 nibbles for 2, 3 or 4 bytes. While the nibbles are sent, the status port reads 0x0 unless another branch is accepted.
- R5: A taken branch without a register target, or any branch while display is off, produces only the 0x5. No marker follows and the data port stays 0x0.
- R6: The data port reads 0x0 in every cycle that carries no address nibble.
- R7: Display enable, size code and target are sampled in the cycle the branch is accepted. Changing the configuration afterwards does not alter that transfer.
- R8: A register-target request that arrives while a transfer is pending or running is held and sent in full after the current transfer. One idle cycle separates the last nibble of the current transfer from the held request's marker.
- R9: The stall output is high, in the same cycle, exactly when a register-target request with display on arrives while the holding slot is full and a transfer is in progress. A stalled strobe is not accepted and produces no 0x5.
- R10: If a branch is accepted in the cycle where a length marker is due, the 0x5 is shown first and the marker follows in the next cycle without such a branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| br_taken | input | 1 | A branch is taken this cycle |
| br_variant | input | 1 | The taken branch takes its target from a register |
| br_target | input | 32 | Target address of the branch |
| cfg_show | input | 1 | Enable target address display |
| cfg_size | input | 2 | Bytes to show: 00 = 2, 01 = 3, 10/11 = 4 |
| pst | output | 4 | Status code: 0x0 idle, 0x5 branch, 0x9/0xA/0xB length marker |
| ddata | output | 4 | Target address nibble, 0x0 when idle |
| stall | output | 1 | Holding slot full; the pipeline must hold the request |

## Verification
A stale nibble counter or shift register appears on the data port within one transfer. It shows as a missing, extra or misordered nibble, or as a nonzero value after the last nibble. A wrong sampled size shows up at once, because the marker that follows the 0x5 has the wrong value. A holding slot that is not cleared or not filled becomes visible about a transfer length later. At that point the held target either never appears after the idle gap, or a phantom transfer appears, or the stall goes high or low one request early.

// File: rtl/btrace_ser.sv
module btrace_ser (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        br_taken,
  input  logic        br_variant,
  input  logic [31:0] br_target,
  input  logic        cfg_show,
  input  logic [1:0]  cfg_size,
  output logic [3:0]  pst,
  output logic [3:0]  ddata,
  output logic        stall
);
  localparam logic [3:0] CODE_BR  = 4'h5;
  localparam logic [3:0] CODE_LEN = 4'h9;

  typedef enum logic [1:0] {S_IDLE, S_MARK, S_SEND} st_t;

  st_t         st;
  logic [31:0] sh, hold_a;
  logic [1:0]  sz, hold_sz;
  logic        hold_v;
  logic [2:0]  cnt;

  wire       req   = br_taken & br_variant & cfg_show;
  wire [1:0] sz_in = (cfg_size == 2'd3) ? 2'd2 : cfg_size;
  wire [2:0] last  = 3'd3 + {sz, 1'b0};

  assign stall = req & hold_v & (st != S_IDLE);
  wire acc = br_taken & ~stall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      sh      <= '0;
      sz      <= '0;
      hold_a  <= '0;
      hold_sz <= '0;
      hold_v  <= 1'b0;
      cnt     <= '0;
      pst     <= '0;
      ddata   <= '0;
    end else begin
      pst   <= acc ? CODE_BR : (st == S_MARK) ? CODE_LEN + {2'b00, sz} : 4'h0;
      ddata <= (st == S_SEND) ? sh[3:0] : 4'h0;

      if (st != S_IDLE && req && !hold_v) begin
        hold_v  <= 1'b1;
        hold_a  <= br_target;
        hold_sz <= sz_in;
      end

      case (st)
        S_IDLE: begin
          if (hold_v) begin
            st      <= S_MARK;
            sh      <= hold_a;
            sz      <= hold_sz;
            hold_v  <= req;
            hold_a  <= br_target;
            hold_sz <= sz_in;
          end else if (req) begin
            st <= S_MARK;
            sh <= br_target;
            sz <= sz_in;
          end
        end
        S_MARK: begin
          if (!acc) begin
            st  <= S_SEND;
            cnt <= '0;
          end
        end
        S_SEND: begin
          sh  <= sh >> 4;
          cnt <= cnt + 3'd1;
          if (cnt == last) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/btrace_ser_chk.sv
module btrace_ser_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       br_taken,
  input logic       br_variant,
  input logic       cfg_show,
  input logic       stall,
  input logic [3:0] pst,
  input logic [3:0] ddata
);
  assert_branch_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (br_taken && !stall) |=> (pst == 4'h5));

  assert_stall_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (br_taken && br_variant && cfg_show));

  assert_quiet_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ddata != 4'h0) |-> (pst == 4'h0 || pst == 4'h5));

  assert_legal_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pst != 4'h0) |-> (pst == 4'h5 || pst == 4'h9 || pst == 4'hA || pst == 4'hB));

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pst == 4'h0 && ddata == 4'h0));
endmodule

bind btrace_ser btrace_ser_chk u_chk (.*);

// File: tb/btrace_ser_tb.sv
module btrace_ser_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        br_taken = 1'b0, br_variant = 1'b0, cfg_show = 1'b0;
  logic [31:0] br_target = '0;
  logic [1:0]  cfg_size = '0;
  logic [3:0]  pst, ddata;
  logic        stall;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  btrace_ser u_dut (
    .clk(clk), .rst_n(rst_n), .br_taken(br_taken), .br_variant(br_variant),
    .br_target(br_target), .cfg_show(cfg_show), .cfg_size(cfg_size),
    .pst(pst), .ddata(ddata), .stall(stall)
  );

  // {taken, variant, show, size[1:0], target[31:0], stall, pst[3:0], ddata[3:0]}
  localparam int NV = 9;
  localparam logic [45:0] VEC [NV] = '{
    {1'b1, 1'b1, 1'b1, 2'd0, 32'h1234ABCD, 1'b0, 4'h5, 4'h0},
    {1'b0, 1'b0, 1'b1, 2'd0, 32'h0,        1'b0, 4'h9, 4'h0},
    {1'b0, 1'b0, 1'b1, 2'd0, 32'h0,        1'b0, 4'h0, 4'hD},
    {1'b0, 1'b0, 1'b1, 2'd0, 32'h0,        1'b0, 4'h0, 4'hC},
    {1'b0, 1'b0, 1'b1, 2'd0, 32'h0,        1'b0, 4'h0, 4'hB},
    {1'b0, 1'b0, 1'b1, 2'd0, 32'h0,        1'b0, 4'h0, 4'hA},
    {1'b0, 1'b0, 1'b1, 2'd0, 32'h0,        1'b0, 4'h0, 4'h0},
    {1'b1, 1'b0, 1'b1, 2'd0, 32'hDEAD0000, 1'b0, 4'h5, 4'h0},
    {1'b0, 1'b0, 1'b1, 2'd0, 32'h0,        1'b0, 4'h0, 4'h0}
  };

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // drive one cycle of inputs at the negedge, check stall, then outputs after the edge
  task automatic cyc(input logic tk, input logic vr, input logic sh, input logic [1:0] sz,
                     input logic [31:0] tg, input logic est, input logic [3:0] ep,
                     input logic [3:0] ed, input string tag);
    br_taken = tk; br_variant = vr; cfg_show = sh; cfg_size = sz; br_target = tg;
    #1;
    chk({31'd0, stall}, {31'd0, est}, {tag, " stall"});
    @(negedge clk);
    chk({28'd0, pst}, {28'd0, ep}, {tag, " pst"});
    chk({28'd0, ddata}, {28'd0, ed}, {tag, " ddata"});
  endtask

  task automatic idle(input logic [3:0] ep, input logic [3:0] ed, input string tag);
    cyc(1'b0, 1'b0, 1'b1, 2'd0, 32'h0, 1'b0, ep, ed, tag);
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({28'd0, pst}, 32'h0, "R1 reset pst");
    chk({28'd0, ddata}, 32'h0, "R1 reset ddata");
    chk({31'd0, stall}, 32'h0, "R1 reset stall");
    rst_n = 1'b1;
    @(negedge clk);
    chk({28'd0, pst}, 32'h0, "R1 after release pst");

    // table: R2/R3/R4 2-byte transfer, R5 non-variant, R6 idle data
    for (int i = 0; i < NV; i++) begin
      logic [45:0] v;
      v = VEC[i];
      cyc(v[45], v[44], v[43], v[42:41], v[40:9], v[8], v[7:4], v[3:0],
          $sformatf("R2 R3 R4 R5 R6 vec%0d", i));
    end

    // R3 R4: 3-byte transfer
    cyc(1, 1, 1, 2'd1, 32'h00FEDCBA, 0, 4'h5, 4'h0, "R2 3B");
    idle(4'hA, 4'h0, "R3 3B marker");
    idle(4'h0, 4'hA, "R4 3B n0"); idle(4'h0, 4'hB, "R4 3B n1");
    idle(4'h0, 4'hC, "R4 3B n2"); idle(4'h0, 4'hD, "R4 3B n3");
    idle(4'h0, 4'hE, "R4 3B n4"); idle(4'h0, 4'hF, "R4 3B n5");
    idle(4'h0, 4'h0, "R6 3B end");

    // R3 R4: 4-byte transfer via size code 11
    cyc(1, 1, 1, 2'd3, 32'h87654321, 0, 4'h5, 4'h0, "R2 4B");
    idle(4'hB, 4'h0, "R3 4B marker");
    for (int k = 1; k <= 8; k++) idle(4'h0, k[3:0], "R4 4B nibble");
    idle(4'h0, 4'h0, "R6 4B end");

    // R5: register target with display off
    cyc(1, 1, 0, 2'd2, 32'hFFFFFFFF, 0, 4'h5, 4'h0, "R5 show off");
    idle(4'h0, 4'h0, "R5 no marker");
    idle(4'h0, 4'h0, "R5 no data");

    // R7: configuration changes after acceptance
    cyc(1, 1, 1, 2'd0, 32'hFFFF0A0B, 0, 4'h5, 4'h0, "R7 start");
    cyc(0, 0, 0, 2'd2, 32'h0, 0, 4'h9, 4'h0, "R7 marker kept");
    cyc(0, 0, 0, 2'd2, 32'h0, 0, 4'h0, 4'hB, "R7 n0");
    cyc(0, 0, 0, 2'd2, 32'h0, 0, 4'h0, 4'h0, "R7 n1");
    cyc(0, 0, 0, 2'd2, 32'h0, 0, 4'h0, 4'hA, "R7 n2");
    cyc(0, 0, 0, 2'd2, 32'h0, 0, 4'h0, 4'h0, "R7 n3");
    cyc(0, 0, 0, 2'd2, 32'h0, 0, 4'h0, 4'h0, "R7 stops after 4");
    idle(4'h0, 4'h0, "R7 idle");

    // R8 R9 R10: overlapping requests
    cyc(1, 1, 1, 2'd0, 32'h00004321, 0, 4'h5, 4'h0, "R2 first");
    cyc(1, 1, 1, 2'd0, 32'h00008765, 0, 4'h5, 4'h0, "R10 branch before marker");
    cyc(1, 1, 1, 2'd0, 32'h0000AAAA, 1, 4'h9, 4'h0, "R9 stall and R10 marker");
    idle(4'h0, 4'h1, "R8 first n0"); idle(4'h0, 4'h2, "R8 first n1");
    idle(4'h0, 4'h3, "R8 first n2"); idle(4'h0, 4'h4, "R8 first n3");
    idle(4'h0, 4'h0, "R8 gap");
    idle(4'h9, 4'h0, "R8 held marker");
    idle(4'h0, 4'h5, "R8 held n0"); idle(4'h0, 4'h6, "R8 held n1");
    idle(4'h0, 4'h7, "R8 held n2"); idle(4'h0, 4'h8, "R8 held n3");
    idle(4'h0, 4'h0, "R9 stalled request dropped");
    idle(4'h0, 4'h0, "R9 still idle");

    // R1: reset in the middle of a transfer with a held request
    cyc(1, 1, 1, 2'd2, 32'h12345678, 0, 4'h5, 4'h0, "R1 pre start");
    cyc(1, 1, 1, 2'd0, 32'h9999, 0, 4'h5, 4'h0, "R1 pre hold");
    idle(4'hB, 4'h0, "R1 pre marker");
    idle(4'h0, 4'h8, "R1 pre n0");
    rst_n = 1'b0;
    @(negedge clk);
    chk({28'd0, pst}, 32'h0, "R1 mid reset pst");
    chk({28'd0, ddata}, 32'h0, "R1 mid reset ddata");
    rst_n = 1'b1;
    for (int k = 0; k < 14; k++) idle(4'h0, 4'h0, "R1 nothing resumes");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule